// File: doc/BRIEF.md
# EDO DRAM Open-Row Access Sequencer

This block sequences accesses to one region of EDO DRAM. It drives the row strobe, the column strobe, the write-enable strobe and a shared row/column address bus. An access is either a single beat or a fixed-length burst. A fresh access spends two cycles on the row phase. Each data beat then takes a pair of column cycles, and the column address advances with every pair. One column-end cycle closes the access. When the row is released, one precharge cycle follows.

A configuration input selects open-row operation. When it is set and the access targeted the designated area, the row strobe stays low after the access and the row is remembered in a register. A later request to the same row in the same area skips the row phase and starts on its first column cycle. A different row, a different area, a refresh request, a bus request or the clearing of the configuration bit causes one precharge cycle first. The next access after that begins again with the row phase.

Refresh and bus requests are level inputs that wait while an access is in progress. After the precharge they are acknowledged with a one-cycle pulse, and this happens before any new access is accepted.

Top module: `edo_row_seq`

## Requirements
- R1: During and straight after reset, dram_ras_n, dram_cas_n and dram_we_n are high, bus_start and xfer_done are low, and req_ready is high.
- R2: An access accepted while no row is open shows the row bits of req_addr on dram_addr for two cycles. dram_ras_n is high in the first of these cycles and low in the second. bus_start rises in the third cycle after the accepting clock edge.
- R3: A single access has one column pair and a burst access (req_burst=1) has BURST_LEN pairs. dram_cas_n is low only in the second cycle of each pair. In pair b, the low log2(BURST_LEN) bits of dram_addr equal the request's column bits plus b, wrapping at BURST_LEN, and the upper column bits are unchanged. xfer_done is high in the cycle right after the last pair. dram_cas_n is never low while dram_ras_n is high.
- R4: With open-row mode off, or for any area other than OPEN_AREA, dram_ras_n is high in the cycle after xfer_done (one precharge cycle), and the next access starts as in R2.
- R5: With cfg_open_row=1 and req_area equal to OPEN_AREA, dram_ras_n stays low in the cycle after xfer_done and while the block waits for the next request.
- R6: With a row open, a request with the same row bits and area OPEN_AREA raises bus_start in the first cycle after the accepting edge.
- R7: With a row open, a request with different row bits causes one precharge cycle and then a two-cycle row phase. bus_start rises in the fourth cycle after the accepting edge, and the row is left open again afterwards.
- R8: With a row open, a request to any area other than OPEN_AREA, even with the same row bits, is timed as in R7. The row is then closed after that access.
- R9: With a row open, raising refresh_req or bus_req drops req_ready at once. In the next cycle dram_ras_n is high (precharge), and in the cycle after that the matching acknowledge pulses. The following access starts as in R2.
- R10: A refresh or bus request raised during an access does not change its beat timing. The access still ends, dram_ras_n is high for one cycle after xfer_done, the acknowledge follows in the next cycle, and the next access starts with a row phase.
- R11: bus_start and xfer_done are one-cycle pulses. dram_we_n is low during the column cycles of a write (req_write=1) and high during those of a read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_open_row | input | 1 | Enables open-row operation |
| req_valid | input | 1 | Access request |
| req_ready | output | 1 | Request accepted on this edge when req_valid is high |
| req_addr | input | ROW_W+COL_W | Row bits above column bits |
| req_area | input | AREA_W | Target area of the request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_burst | input | 1 | 1 = BURST_LEN beats, 0 = single beat |
| refresh_req | input | 1 | Refresh request level |
| refresh_ack | output | 1 | One-cycle refresh handoff pulse |
| bus_req | input | 1 | External bus request level |
| bus_ack | output | 1 | One-cycle bus handoff pulse |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_addr | output | max(ROW_W,COL_W) | Multiplexed row/column address |
| bus_start | output | 1 | Pulse at the first column cycle |
| xfer_done | output | 1 | Pulse after the final beat |

## Verification
The bench builds the block with ROW_W=4, COL_W=4, AREA_W=2, OPEN_AREA=3, BURST_LEN=4 and REG_OUT=0. This keeps the address space small enough to sweep every pairing of row match, area match, burst length and open-row setting across consecutive accesses. The expected start latency (1, 3 or 4 cycles) and the burst length come from a model of which row is open. Column wrap-around shows up in the sweep because base columns near the top of a wrap group occur. Refresh and bus handoffs are exercised from the open state, from idle and in the middle of a burst.

// File: rtl/edo_seq_pkg.sv
package edo_seq_pkg;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_TR1,
      ST_TR2,
      ST_TC1,
      ST_TC2,
      ST_TCE,
      ST_TPC,
      ST_OPEN,
      ST_GRANT
   } seq_state_t;

   function automatic int max_int(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/edo_row_tracker.sv
module edo_row_tracker #(
   parameter int ROW_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic             clear_i,
   input  logic [ROW_W-1:0] row_in_i,
   input  logic [ROW_W-1:0] cmp_row_i,
   output logic             open_o,
   output logic             hit_o
);

   logic [ROW_W-1:0] row_q;
   logic             open_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         row_q  <= '0;
         open_q <= 1'b0;
      end else if (clear_i) begin
         open_q <= 1'b0;
      end else if (load_i) begin
         row_q  <= row_in_i;
         open_q <= 1'b1;
      end
   end

   assign open_o = open_q;
   assign hit_o  = open_q && (row_q == cmp_row_i);

   AST_LOAD_CLEAR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(load_i && clear_i));  // R5

   AST_HIT_NEEDS_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(open_q) |-> $past(load_i));  // R5

endmodule

// File: rtl/edo_beat_ctr.sv
module edo_beat_ctr #(
   parameter int BURST_LEN = 4,
   localparam int BEAT_W = $clog2(BURST_LEN)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr_i,
   input  logic              adv_i,
   input  logic              burst_i,
   output logic [BEAT_W-1:0] beat_o,
   output logic              last_o
);

   localparam logic [BEAT_W-1:0] LAST_IDX = BEAT_W'(BURST_LEN - 1);

   logic [BEAT_W-1:0] beat_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         beat_q <= '0;
      end else if (clr_i) begin
         beat_q <= '0;
      end else if (adv_i) begin
         beat_q <= beat_q + 1'b1;
      end
   end

   assign beat_o = beat_q;
   assign last_o = burst_i ? (beat_q == LAST_IDX) : (beat_q == '0);

   AST_ADV_ONLY_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
      adv_i |-> !clr_i);  // R3

endmodule

// File: rtl/edo_seq_fsm.sv
module edo_seq_fsm
   import edo_seq_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cfg_open_i,
   input  logic       req_valid_i,
   input  logic       row_hit_i,
   input  logic       req_area_ok_i,
   input  logic       cur_area_ok_i,
   input  logic       refresh_req_i,
   input  logic       bus_req_i,
   input  logic       last_beat_i,
   output seq_state_t state_o,
   output logic       ready_o,
   output logic       accept_o,
   output logic       refresh_ack_o,
   output logic       bus_ack_o
);

   seq_state_t state_q, state_d;
   logic       pend_q, pend_d;
   logic       close_cause;
   logic       hit_now;

   assign close_cause = refresh_req_i || bus_req_i;
   assign hit_now     = row_hit_i && req_area_ok_i;
   assign ready_o     = ((state_q == ST_IDLE) || ((state_q == ST_OPEN) && cfg_open_i))
                        && !close_cause;
   assign accept_o    = ready_o && req_valid_i;

   always_comb begin
      state_d = state_q;
      pend_d  = pend_q;
      case (state_q)
         ST_IDLE: begin
            if (close_cause)   state_d = ST_GRANT;
            else if (accept_o) state_d = ST_TR1;
         end
         ST_TR1:  state_d = ST_TR2;
         ST_TR2:  state_d = ST_TC1;
         ST_TC1:  state_d = ST_TC2;
         ST_TC2:  state_d = last_beat_i ? ST_TCE : ST_TC1;
         ST_TCE: begin
            if (cfg_open_i && cur_area_ok_i && !close_cause) state_d = ST_OPEN;
            else                                              state_d = ST_TPC;
         end
         ST_OPEN: begin
            if (close_cause || !cfg_open_i) begin
               state_d = ST_TPC;
            end else if (accept_o) begin
               if (hit_now) begin
                  state_d = ST_TC1;
               end else begin
                  state_d = ST_TPC;
                  pend_d  = 1'b1;
               end
            end
         end
         ST_TPC: begin
            if (pend_q) begin
               state_d = ST_TR1;
               pend_d  = 1'b0;
            end else if (close_cause) begin
               state_d = ST_GRANT;
            end else begin
               state_d = ST_IDLE;
            end
         end
         ST_GRANT: state_d = ST_IDLE;
         default:  state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         pend_q  <= 1'b0;
      end else begin
         state_q <= state_d;
         pend_q  <= pend_d;
      end
   end

   assign state_o       = state_q;
   assign refresh_ack_o = (state_q == ST_GRANT) && refresh_req_i;
   assign bus_ack_o     = (state_q == ST_GRANT) && bus_req_i && !refresh_req_i;

   AST_HIT_SKIPS_ROW: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_TC1 && $past(state_q) == ST_OPEN) |-> $past(row_hit_i && req_area_ok_i));  // R6

   AST_GRANT_AFTER_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_GRANT) |-> ($past(state_q) == ST_TPC || $past(state_q) == ST_IDLE));  // R9

   AST_OPEN_ONLY_AREA: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_OPEN && $past(state_q) == ST_TCE) |-> $past(cfg_open_i && cur_area_ok_i));  // R5

   AST_ROW_BEFORE_COL: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_TR2) |-> ($past(state_q) == ST_TR1));  // R2

endmodule

// File: rtl/edo_row_seq.sv
module edo_row_seq
   import edo_seq_pkg::*;
#(
   parameter int ROW_W     = 12,
   parameter int COL_W     = 10,
   parameter int AREA_W    = 3,
   parameter int OPEN_AREA = 3,
   parameter int BURST_LEN = 4,
   parameter bit REG_OUT   = 1'b0,
   localparam int ADDR_W   = ROW_W + COL_W,
   localparam int MUX_W    = max_int(ROW_W, COL_W),
   localparam int BEAT_W   = $clog2(BURST_LEN)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_open_row,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [AREA_W-1:0] req_area,
   input  logic              req_write,
   input  logic              req_burst,
   input  logic              refresh_req,
   output logic              refresh_ack,
   input  logic              bus_req,
   output logic              bus_ack,
   output logic              dram_ras_n,
   output logic              dram_cas_n,
   output logic              dram_we_n,
   output logic [MUX_W-1:0]  dram_addr,
   output logic              bus_start,
   output logic              xfer_done
);

   generate
      if (BURST_LEN < 2 || (BURST_LEN & (BURST_LEN - 1)) != 0) begin : g_bad_burst
         $error("BURST_LEN must be a power of two, at least 2");
      end
      if (COL_W <= BEAT_W) begin : g_bad_col
         $error("COL_W must exceed log2(BURST_LEN)");
      end
      if (OPEN_AREA < 0 || OPEN_AREA >= (1 << AREA_W)) begin : g_bad_area
         $error("OPEN_AREA must fit in AREA_W bits");
      end
   endgenerate

   localparam logic [AREA_W-1:0] OPEN_AREA_V = AREA_W'(OPEN_AREA);

   seq_state_t        state;
   logic              accept;
   logic              row_hit;
   logic              row_open;
   logic              last_beat;
   logic [BEAT_W-1:0] beat;

   logic [ROW_W-1:0]  lat_row;
   logic [COL_W-1:0]  lat_col;
   logic              lat_area_ok;
   logic              lat_write;
   logic              lat_burst;

   wire [ROW_W-1:0] in_row     = req_addr[ADDR_W-1:COL_W];
   wire [COL_W-1:0] in_col     = req_addr[COL_W-1:0];
   wire             in_area_ok = (req_area == OPEN_AREA_V);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lat_row     <= '0;
         lat_col     <= '0;
         lat_area_ok <= 1'b0;
         lat_write   <= 1'b0;
         lat_burst   <= 1'b0;
      end else if (accept) begin
         lat_row     <= in_row;
         lat_col     <= in_col;
         lat_area_ok <= in_area_ok;
         lat_write   <= req_write;
         lat_burst   <= req_burst;
      end
   end

   edo_seq_fsm u_fsm (
      .clk           (clk),
      .rst_n         (rst_n),
      .cfg_open_i    (cfg_open_row),
      .req_valid_i   (req_valid),
      .row_hit_i     (row_hit),
      .req_area_ok_i (in_area_ok),
      .cur_area_ok_i (lat_area_ok),
      .refresh_req_i (refresh_req),
      .bus_req_i     (bus_req),
      .last_beat_i   (last_beat),
      .state_o       (state),
      .ready_o       (req_ready),
      .accept_o      (accept),
      .refresh_ack_o (refresh_ack),
      .bus_ack_o     (bus_ack)
   );

   edo_row_tracker #(.ROW_W(ROW_W)) u_rows (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_i    (state == ST_TR2),
      .clear_i   (state == ST_TPC),
      .row_in_i  (lat_row),
      .cmp_row_i (in_row),
      .open_o    (row_open),
      .hit_o     (row_hit)
   );

   edo_beat_ctr #(.BURST_LEN(BURST_LEN)) u_beats (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr_i   (state != ST_TC1 && state != ST_TC2),
      .adv_i   (state == ST_TC2),
      .burst_i (lat_burst),
      .beat_o  (beat),
      .last_o  (last_beat)
   );

   logic [BEAT_W-1:0] col_low;
   logic [COL_W-1:0]  col_cur;
   logic              in_row_ph, in_col_ph, ras_act;
   logic              ras_n_c, cas_n_c, we_n_c, start_c, done_c;
   logic [MUX_W-1:0]  addr_c;

   assign col_low   = lat_col[BEAT_W-1:0] + beat;
   assign col_cur   = {lat_col[COL_W-1:BEAT_W], col_low};
   assign in_row_ph = (state == ST_TR1) || (state == ST_TR2);
   assign in_col_ph = (state == ST_TC1) || (state == ST_TC2);
   assign ras_act   = (state == ST_TR2) || in_col_ph || (state == ST_TCE) || (state == ST_OPEN);

   always_comb begin
      ras_n_c = !ras_act;
      cas_n_c = !(state == ST_TC2);
      we_n_c  = !(lat_write && (in_row_ph || in_col_ph || state == ST_TCE));
      start_c = (state == ST_TC1) && (beat == '0);
      done_c  = (state == ST_TCE);
      if (in_row_ph)      addr_c = MUX_W'(lat_row);
      else if (in_col_ph) addr_c = MUX_W'(col_cur);
      else                addr_c = '0;
   end

   generate
      if (REG_OUT) begin : g_out_reg
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               dram_ras_n <= 1'b1;
               dram_cas_n <= 1'b1;
               dram_we_n  <= 1'b1;
               dram_addr  <= '0;
               bus_start  <= 1'b0;
               xfer_done  <= 1'b0;
            end else begin
               dram_ras_n <= ras_n_c;
               dram_cas_n <= cas_n_c;
               dram_we_n  <= we_n_c;
               dram_addr  <= addr_c;
               bus_start  <= start_c;
               xfer_done  <= done_c;
            end
         end
      end else begin : g_out_comb
         assign dram_ras_n = ras_n_c;
         assign dram_cas_n = cas_n_c;
         assign dram_we_n  = we_n_c;
         assign dram_addr  = addr_c;
         assign bus_start  = start_c;
         assign xfer_done  = done_c;
      end
   endgenerate

   AST_CAS_UNDER_RAS: assert property (@(posedge clk) disable iff (!rst_n)
      !dram_cas_n |-> !dram_ras_n);  // R3

   AST_START_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      bus_start |=> !bus_start);  // R11

   AST_DONE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_done |=> !xfer_done);  // R11

   AST_ACK_RAS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (refresh_ack || bus_ack) |-> (dram_ras_n && !row_open));  // R9

endmodule

// File: tb/edo_row_seq_tb.sv
`timescale 1ns/1ps
module edo_row_seq_tb_top;

   localparam int ROW_W = 4;
   localparam int COL_W = 4;
   localparam int AREA_W = 2;
   localparam int OPEN_AREA = 3;
   localparam int BURST_LEN = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_open_row = 1'b0;
   logic       req_valid = 1'b0;
   logic       req_ready;
   logic [7:0] req_addr = '0;
   logic [1:0] req_area = '0;
   logic       req_write = 1'b0;
   logic       req_burst = 1'b0;
   logic       refresh_req = 1'b0;
   logic       refresh_ack;
   logic       bus_req = 1'b0;
   logic       bus_ack;
   logic       dram_ras_n, dram_cas_n, dram_we_n;
   logic [3:0] dram_addr;
   logic       bus_start, xfer_done;

   always #2.5 clk = ~clk;

   edo_row_seq #(
      .ROW_W(ROW_W), .COL_W(COL_W), .AREA_W(AREA_W), .OPEN_AREA(OPEN_AREA),
      .BURST_LEN(BURST_LEN), .REG_OUT(1'b0)
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_open_row(cfg_open_row),
      .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
      .req_area(req_area), .req_write(req_write), .req_burst(req_burst),
      .refresh_req(refresh_req), .refresh_ack(refresh_ack),
      .bus_req(bus_req), .bus_ack(bus_ack),
      .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n),
      .dram_addr(dram_addr), .bus_start(bus_start), .xfer_done(xfer_done)
   );

   int n_tests = 0;
   int n_fail = 0;
   int cyc = 0;
   int raise_at = 0;
   bit raise_bus = 1'b0;
   bit m_open = 1'b0;
   logic [3:0] m_row = '0;

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
      end
   endtask

   task automatic step();
      @(negedge clk);
      cyc++;
      if (raise_at != 0 && cyc == raise_at) begin
         if (raise_bus) bus_req = 1'b1;
         else           refresh_req = 1'b1;
      end
   endtask

   task automatic access(input logic [3:0] row, input logic [3:0] col, input logic [1:0] area,
                         input bit wr, input bit bst, input int rat, input bit rbus);
      int exp_lat, nb, guard;
      bit exp_open;
      string lat_req;
      logic [3:0] col_exp;
      if (!m_open) begin
         exp_lat = 3; lat_req = "R2";
      end else if (row == m_row && area == 2'(OPEN_AREA)) begin
         exp_lat = 1; lat_req = "R6";
      end else begin
         exp_lat = 4; lat_req = (area != 2'(OPEN_AREA)) ? "R8" : "R7";
      end
      @(negedge clk);
      req_valid = 1'b1; req_addr = {row, col}; req_area = area;
      req_write = wr; req_burst = bst;
      #1;
      guard = 0;
      while (!req_ready && guard < 50) begin
         @(negedge clk); #1; guard++;
      end
      @(posedge clk);
      cyc = 0;
      raise_at = rat; raise_bus = rbus;
      step();
      req_valid = 1'b0;
      while (!bus_start && cyc < 12) begin
         if (exp_lat >= 3 && cyc == exp_lat - 2)
            check(dram_ras_n == 1'b1 && dram_addr == row, "R2", {dram_ras_n, dram_addr}, {1'b1, row});
         if (exp_lat >= 3 && cyc == exp_lat - 1)
            check(dram_ras_n == 1'b0 && dram_addr == row, "R2", {dram_ras_n, dram_addr}, {1'b0, row});
         if (exp_lat == 4 && cyc == 1)
            check(dram_ras_n == 1'b1, lat_req, dram_ras_n, 1);
         step();
      end
      check(cyc == exp_lat, lat_req, cyc, exp_lat);
      nb = bst ? BURST_LEN : 1;
      for (int b = 0; b < nb; b++) begin
         col_exp = {col[3:2], 2'(col[1:0] + 2'(b))};
         check(dram_addr == col_exp && dram_cas_n == 1'b1, "R3", {dram_cas_n, dram_addr}, {1'b1, col_exp});
         step();
         check(dram_cas_n == 1'b0 && dram_addr == col_exp, "R3", {dram_cas_n, dram_addr}, {1'b0, col_exp});
         check(dram_we_n == !wr && bus_start == 1'b0, "R11", {dram_we_n, bus_start}, {!wr, 1'b0});
         step();
      end
      check(xfer_done == 1'b1, "R3", xfer_done, 1);
      exp_open = cfg_open_row && (area == 2'(OPEN_AREA)) && (rat == 0);
      step();
      check(xfer_done == 1'b0, "R11", xfer_done, 0);
      if (exp_open) check(dram_ras_n == 1'b0, "R5", dram_ras_n, 0);
      else          check(dram_ras_n == 1'b1, (rat != 0) ? "R10" : "R4", dram_ras_n, 1);
      if (rat != 0) begin
         step();
         if (rbus) check(bus_ack == 1'b1 && refresh_ack == 1'b0, "R10", {bus_ack, refresh_ack}, 2);
         else      check(refresh_ack == 1'b1 && bus_ack == 1'b0, "R10", {bus_ack, refresh_ack}, 1);
         refresh_req = 1'b0; bus_req = 1'b0;
      end
      raise_at = 0;
      m_open = exp_open;
      m_row = row;
   endtask

   task automatic close_by(input bit use_bus);
      @(negedge clk);
      if (use_bus) bus_req = 1'b1; else refresh_req = 1'b1;
      #1;
      check(req_ready == 1'b0, "R9", req_ready, 0);
      @(negedge clk);
      check(dram_ras_n == 1'b1 && refresh_ack == 1'b0 && bus_ack == 1'b0, "R9",
            {dram_ras_n, refresh_ack, bus_ack}, 4);
      @(negedge clk);
      if (use_bus) check(bus_ack == 1'b1, "R9", bus_ack, 1);
      else         check(refresh_ack == 1'b1, "R9", refresh_ack, 1);
      refresh_req = 1'b0; bus_req = 1'b0;
      m_open = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      #1;
      check(dram_ras_n && dram_cas_n && dram_we_n, "R1", {dram_ras_n, dram_cas_n, dram_we_n}, 7);
      check(!bus_start && !xfer_done && req_ready, "R1", {bus_start, xfer_done, req_ready}, 1);
      rst_n = 1'b1;
      @(negedge clk);
      check(dram_ras_n && dram_cas_n && req_ready, "R1", {dram_ras_n, dram_cas_n, req_ready}, 7);

      for (int cfg = 0; cfg < 2; cfg++) begin
         if (m_open) close_by(1'b0);
         @(negedge clk);
         cfg_open_row = cfg[0];
         for (int r0 = 0; r0 < 4; r0++) begin
            for (int a1 = 0; a1 < 2; a1++) begin
               for (int same = 0; same < 2; same++) begin
                  for (int bst = 0; bst < 2; bst++) begin
                     logic [3:0] c0, r1;
                     c0 = 4'(r0 * 5 + same * 3 + bst * 2 + 3);
                     r1 = same[0] ? 4'(r0 * 3) : 4'(r0 * 3 + 7);
                     access(4'(r0 * 3), c0, 2'(OPEN_AREA), bst[0], bst[0], 0, 1'b0);
                     access(r1, 4'(c0 + 1), a1[0] ? 2'(OPEN_AREA) : 2'd1,
                            !bst[0], 1'b1, 0, 1'b0);
                  end
               end
            end
         end
      end

      // open row closed by refresh and by bus request, then fresh start
      cfg_open_row = 1'b1;
      if (m_open) close_by(1'b0);
      access(4'd9, 4'd2, 2'd3, 1'b0, 1'b1, 0, 1'b0);
      access(4'd9, 4'd7, 2'd3, 1'b1, 1'b0, 0, 1'b0);
      close_by(1'b0);
      access(4'd9, 4'd1, 2'd3, 1'b0, 1'b0, 0, 1'b0);
      close_by(1'b1);
      access(4'd9, 4'd1, 2'd3, 1'b0, 1'b1, 0, 1'b0);

      // mid-burst refresh and bus requests are deferred
      access(4'd9, 4'd6, 2'd3, 1'b0, 1'b1, 4, 1'b0);
      access(4'd5, 4'd3, 2'd3, 1'b1, 1'b1, 6, 1'b1);
      cfg_open_row = 1'b0;
      access(4'd2, 4'd0, 2'd0, 1'b0, 1'b1, 5, 1'b0);

      // refresh from idle: handoff on the next cycle
      repeat (2) @(negedge clk);
      refresh_req = 1'b1;
      @(negedge clk);
      check(refresh_ack == 1'b1 && dram_ras_n == 1'b1, "R9", {refresh_ack, dram_ras_n}, 3);
      refresh_req = 1'b0;
      access(4'd2, 4'd0, 2'd0, 1'b0, 1'b0, 0, 1'b0);

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule